// File: doc/BRIEF.md
# Converter Control Register Bank with Atomic Bit Operations

This block is the software-visible register file of an analog-to-digital converter controller. It sits on a plain 32-bit read/write bus addressed by a byte offset. It stores six 32-bit control words: three general control words, a channel selection word, a scan selection word and a port configuration word. Each word owns a 16-byte slot.

Each slot has four write aliases. Offset bits 3:2 select how the incoming data is applied to the stored word: it can replace the word, or it can serve as a mask that clears, sets or flips bits. Software can therefore change individual bits in one bus write, with no read-modify-write sequence. All four aliases of a slot act on the same storage, and a read through any of them returns the whole word.

Above the control slots sits a window of sixteen result-buffer slots. In this block they read as zero and ignore writes. Filling them is left to a future conversion engine. Accesses at or beyond the end of the window are harmless. The one unassigned slot inside the window raises a one-cycle error flag when it is accessed.

Top module: `adc_regbank`

## Requirements
- R1: While `rst` is high on a clock edge, all six control words become zero, and `rdata` and `err` become zero.
- R2: A write with offset bits 3:2 = 00 replaces the addressed word with `wdata`.
- R3: A write with offset bits 3:2 = 01 clears every bit of the addressed word that is 1 in `wdata` and leaves the other bits unchanged.
- R4: A write with offset bits 3:2 = 10 sets every bit of the addressed word that is 1 in `wdata` and leaves the other bits unchanged.
- R5: A write with offset bits 3:2 = 11 inverts every bit of the addressed word that is 1 in `wdata` and leaves the other bits unchanged.
- R6: Offset bits 1:0 and 3:2 do not affect which word is selected. A read through any of the four aliases returns the word's full current value.
- R7: Read data appears on `rdata` in the clock cycle after `rd_en` is sampled high. In any cycle that follows a cycle without `rd_en`, `rdata` is zero.
- R8: Offsets 0x070 through 0x16F are result-buffer slots. Reads there return zero, writes there change no control word, and `err` stays low.
- R9: Offsets at or above 0x170 read as zero, their writes change no control word, and `err` stays low.
- R10: An access (read or write) to offsets 0x030 through 0x03F reads zero and changes no word. It drives `err` high for exactly the following cycle.
- R11: When a read and a write hit the same word in the same cycle, the read returns the value the word held before that write.
- R12: The control words live at slot bases 0x000, 0x010, 0x020, 0x040, 0x050 and 0x060, one word per slot. A write to one word leaves the other five unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, applied at the sampling edge |
| rd_en | input | 1 | Read strobe, data returned one cycle later |
| addr | input | 12 | Byte offset into the bank |
| wdata | input | 32 | Write data or bit mask |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle flag for an access to the unassigned slot |

## Verification
The bench sweeps every alias of every word with random data and masks against a behavioural model. A decoder that looked at bits 3:2 when selecting the word would scatter writes across neighbouring words. Operation codes that were swapped would show up as a clear where a set was expected. The bench probes both edges of the buffer window (0x070, 0x16C) and the first offsets beyond it (0x170, 0xFF0). A bound off by one slot would either alias a control word there or raise `err`. It also reads and writes one word in the same cycle, where a read path taken after the write would return the new value instead of the old one.

// File: rtl/adcreg_pkg.sv
package adcreg_pkg;

    localparam int DATA_W          = 32;
    localparam int NUM_REGS        = 6;
    localparam int NUM_BUFS        = 16;
    localparam int SLOT_SHIFT      = 4;
    localparam int WINDOW_BYTES    = 'h170;
    localparam int BUF_FIRST_SLOT  = 7;
    localparam int REG_IDX_W       = $clog2(NUM_REGS);

    // slot number (offset >> SLOT_SHIFT) for each control word
    localparam int REG_SLOT [NUM_REGS] = '{0, 1, 2, 4, 5, 6};

    typedef enum logic [1:0] {
        OP_ASSIGN = 2'b00,
        OP_CLEAR  = 2'b01,
        OP_SET    = 2'b10,
        OP_FLIP   = 2'b11
    } wr_op_e;

    typedef struct packed {
        logic                 in_win;
        logic                 is_reg;
        logic                 is_buf;
        logic                 is_hole;
        logic [REG_IDX_W-1:0] reg_idx;
        wr_op_e               op;
    } dec_t;

    function automatic logic [DATA_W-1:0] apply_op(
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] mask,
        input wr_op_e            op
    );
        logic [DATA_W-1:0] res;
        unique case (op)
            OP_ASSIGN: res = mask;
            OP_CLEAR:  res = cur & ~mask;
            OP_SET:    res = cur | mask;
            OP_FLIP:   res = cur ^ mask;
            default:   res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/adcreg_decode.sv
module adcreg_decode
    import adcreg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int SLOT_W = ADDR_W - SLOT_SHIFT;

    logic [SLOT_W-1:0] slot;
    assign slot = addr[ADDR_W-1:SLOT_SHIFT];

    always_comb begin
        dec         = '0;
        dec.op      = wr_op_e'(addr[3:2]);
        dec.in_win  = (addr < ADDR_W'(WINDOW_BYTES));
        for (int i = 0; i < NUM_REGS; i++) begin
            if (dec.in_win && slot == SLOT_W'(REG_SLOT[i])) begin
                dec.is_reg  = 1'b1;
                dec.reg_idx = REG_IDX_W'(i);
            end
        end
        dec.is_buf  = dec.in_win
                    && (slot >= SLOT_W'(BUF_FIRST_SLOT))
                    && (slot <  SLOT_W'(BUF_FIRST_SLOT + NUM_BUFS));
        dec.is_hole = dec.in_win && !dec.is_reg && !dec.is_buf;
    end

endmodule

// File: rtl/adcreg_cell.sv
module adcreg_cell
    import adcreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel,
    input  wr_op_e            op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_sel)
            q <= apply_op(q, wdata, op);
    end

    AST_ASSIGN_LOADS: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && op == OP_ASSIGN) |=> q == $past(wdata)); // R2
    AST_CLEAR_BITS: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && op == OP_CLEAR) |=> ((q & $past(wdata)) == '0)
            && ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))); // R3
    AST_SET_BITS: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata))
            && ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))); // R4
    AST_FLIP_BITS: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && op == OP_FLIP) |=> (q ^ $past(q)) == $past(wdata)); // R5
    AST_UNSELECTED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_sel |=> $stable(q)); // R12

endmodule

// File: rtl/adc_regbank.sv
module adc_regbank
    import adcreg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);
    dec_t dec;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic [DATA_W-1:0]               rd_next;

    adcreg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (addr),
        .dec  (dec)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        logic sel;
        assign sel = wr_en && dec.is_reg && (dec.reg_idx == REG_IDX_W'(g));
        adcreg_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .wr_sel(sel),
            .op    (dec.op),
            .wdata (wdata),
            .q     (regs_q[g])
        );
    end

    always_comb begin
        rd_next = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (dec.is_reg && dec.reg_idx == REG_IDX_W'(i))
                rd_next = regs_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            rdata <= rd_en ? rd_next : '0;
            err   <= (rd_en || wr_en) && dec.is_hole;
        end
    end

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rdata == '0); // R7
    AST_OUTSIDE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !dec.in_win) |=> rdata == '0); // R9
    AST_NONREG_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !dec.is_reg) |=> $stable(regs_q)); // R8
    AST_ERR_FROM_HOLE: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(dec.is_hole)); // R10

endmodule

// File: tb/adc_regbank_tb.sv
`timescale 1ns/1ps
module adc_regbank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl [6];

    always #4 clk = ~clk;   // 125 MHz

    adc_regbank u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
    );

    function automatic int ref_idx(input logic [11:0] a);
        if (a >= 12'h170) return -1;
        case (a[11:4])
            8'd0: return 0;
            8'd1: return 1;
            8'd2: return 2;
            8'd4: return 3;
            8'd5: return 4;
            8'd6: return 5;
            default: return -1;
        endcase
    endfunction

    function automatic bit ref_hole(input logic [11:0] a);
        return (a < 12'h170) && (a[11:4] == 8'd3);
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input bit we, input bit re, input logic [11:0] a,
                        input logic [31:0] d, input string tag);
        logic [31:0] exp_rd;
        bit          exp_err;
        int          idx;
        wr_en = we; rd_en = re; addr = a; wdata = d;
        @(posedge clk);
        idx     = ref_idx(a);
        exp_rd  = (re && idx >= 0) ? mdl[idx] : 32'h0;
        exp_err = (we || re) && ref_hole(a);
        if (we && idx >= 0) begin
            case (a[3:2])
                2'b00: mdl[idx] = d;
                2'b01: mdl[idx] = mdl[idx] & ~d;
                2'b10: mdl[idx] = mdl[idx] | d;
                default: mdl[idx] = mdl[idx] ^ d;
            endcase
        end
        @(negedge clk);
        check32({tag, " rdata"}, rdata, exp_rd);
        check32({tag, " err"}, {31'b0, err}, {31'b0, exp_err});
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        step(1'b0, 1'b1, a, 32'h0, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        step(1'b1, 1'b0, a, d, tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 0; rd_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 6; i++) mdl[i] = 32'h0;
        check32("R1 rdata in reset", rdata, 32'h0);
        check32("R1 err in reset", {31'b0, err}, 32'h0);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] bases [6] = '{12'h000, 12'h010, 12'h020, 12'h040, 12'h050, 12'h060};
        @(negedge clk);
        do_reset();
        for (int i = 0; i < 6; i++) rd(bases[i], "R1 reset value");

        wr(12'h000, 32'h1234_5678, "R2 assign");
        rd(12'h000, "R2 readback");
        wr(12'h004, 32'h0000_FF00, "R3 clear");
        rd(12'h000, "R3 readback");
        wr(12'h018, 32'hA000_000F, "R4 set");
        rd(12'h010, "R4 readback");
        wr(12'h06C, 32'hFFFF_0000, "R5 flip");
        rd(12'h060, "R5 readback");
        wr(12'h06D, 32'h0F0F_0000, "R5 flip byte offset");
        rd(12'h063, "R6 unaligned alias read");
        rd(12'h004, "R6 alias read 01");
        rd(12'h008, "R6 alias read 10");
        rd(12'h00C, "R6 alias read 11");

        step(1'b0, 1'b0, 12'h000, 32'h0, "R7 idle cycle");
        rd(12'h000, "R7 one-cycle latency");
        step(1'b0, 1'b0, 12'h000, 32'h0, "R7 zero after read");

        wr(12'h070, 32'hFFFF_FFFF, "R8 first buffer write");
        wr(12'h16C, 32'hFFFF_FFFF, "R8 last buffer write");
        rd(12'h070, "R8 first buffer read");
        rd(12'h160, "R8 last buffer read");
        for (int i = 0; i < 6; i++) rd(bases[i], "R8 words unchanged");

        wr(12'h170, 32'hDEAD_BEEF, "R9 write at bound");
        wr(12'hFF0, 32'hDEAD_BEEF, "R9 write far");
        rd(12'h170, "R9 read at bound");
        rd(12'h17C, "R9 read alias beyond");
        for (int i = 0; i < 6; i++) rd(bases[i], "R9 words unchanged");

        wr(12'h030, 32'hFFFF_FFFF, "R10 hole write");
        step(1'b0, 1'b0, 12'h000, 32'h0, "R10 err single cycle");
        rd(12'h03C, "R10 hole read");
        for (int i = 0; i < 6; i++) rd(bases[i], "R10 words unchanged");

        wr(12'h020, 32'h5555_AAAA, "R11 preset");
        step(1'b1, 1'b1, 12'h020, 32'h0123_4567, "R11 read old on write");
        rd(12'h020, "R11 new value");

        for (int i = 0; i < 6; i++) wr(bases[i], 32'h1111_1111 * (i + 1), "R12 distinct fill");
        wr(12'h048, 32'h8000_0000, "R12 set one");
        for (int i = 0; i < 6; i++) rd(bases[i], "R12 isolation");

        for (int n = 0; n < 600; n++) begin
            logic [11:0] a;
            int          s;
            s = $urandom_range(0, 7);
            a = {s[7:0], 4'h0} | 12'($urandom_range(0, 15));
            step(1'($urandom), 1'($urandom), a, $urandom, "R6 random alias sweep");
        end

        do_reset();
        for (int i = 0; i < 6; i++) rd(bases[i], "R1 reset clears words");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule